// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation speed of a single fan as the length of one tachometer period. The period is expressed in ticks of a scaled reference clock, so a slow fan gives a large count and a fast fan gives a small one. The 8-bit result saturates at full scale. A full-scale result stands for a stalled or nearly stopped fan.

A monitoring sequencer pulses `start` and selects a prescale with `div_sel`. The asynchronous tachometer line passes through a two-flop synchroniser and a three-sample agreement filter. Slow or noisy edges therefore produce one clean rising edge each. The measurement runs from the first filtered rising edge after `start` to the next one. The block then pulses `done`, presents the count and flags a violation when the count is above the programmed `limit`. The prescale lets one nominal count, such as 153, correspond to fan speed ranges that differ by factors of two.

Top module: `fan_tach_counter`

## Requirements
- R1: After reset, `count` is 0, `done` is 0 and `over_limit` is 0.
- R2: With N clock cycles between two consecutive tachometer rising edges, the result is floor(N / D). D is the prescale that `div_sel` chooses when `start` is pulsed: 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 8.
- R3: When the period reaches 255·D cycles or more, the measurement ends at the moment the count reaches 255. It reports 255 without waiting for the second edge.
- R4: When no rising edge arrives at all after `start`, the block reports 255 roughly 255·D cycles after `start`.
- R5: A tachometer pulse shorter than three clock cycles creates no edge and does not shorten the measured period.
- R6: At each result, `over_limit` is 1 only if the count is strictly greater than `limit`. A count equal to `limit` gives 0.
- R7: A rising edge before `start` is ignored. The measurement begins at the first edge after it. A `start` during a measurement aborts that measurement without a result and restarts it.
- R8: `done` is a one-cycle pulse for each result. `count` and `over_limit` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Asynchronous tachometer line |
| div_sel | input | 2 | Prescale select, latched at start |
| start | input | 1 | One-cycle request to begin a measurement |
| limit | input | 8 | Count limit for the violation flag |
| count | output | 8 | Last measured period count |
| done | output | 1 | One-cycle pulse when a new result is valid |
| over_limit | output | 1 | Last count was greater than the limit |

## Verification
Clean square waves at every prescale setting show that the count scales exactly as floor(N/D). Periods of 153 cycles measured against limits of 152 and 153 separate the strict comparison from a non-strict one. An over-long period and a dead line separate the early saturation exit from waiting for an edge. A two-cycle glitch inside the low phase, an edge placed before `start`, and a second `start` issued during a measurement show that the filter rejects short pulses and that only edges after the latest `start` are counted.

// File: rtl/fan_tach_counter.sv
module fan_tach_counter #(
  parameter int CNT_W  = 8,
  parameter int FILT_N = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             over_limit
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_MEAS} state_t;

  logic [1:0]        sync_q;
  logic [FILT_N-1:0] hist_q;
  logic              filt_q, filt_d;
  state_t            state_q;
  logic [SEL_W-1:0]  div_q;
  logic [PRE_W-1:0]  pre_q, pre_top;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              rise, tick, sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tach_in};
      hist_q <= {hist_q[FILT_N-2:0], sync_q[1]};
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
      filt_d <= filt_q;
    end
  end

  assign rise    = filt_q & ~filt_d;
  assign pre_top = PRE_W'((32'd1 << div_q) - 32'd1);
  assign tick    = (pre_q == pre_top);
  assign cnt_nx  = (tick && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  assign sat     = (cnt_nx == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      div_q      <= '0;
      pre_q      <= '0;
      cnt_q      <= '0;
      count      <= '0;
      done       <= 1'b0;
      over_limit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state_q <= S_ARM;
        div_q   <= div_sel;
        pre_q   <= '0;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          S_ARM: begin
            if (rise) begin
              state_q <= S_MEAS;
              pre_q   <= '0;
              cnt_q   <= '0;
            end else if (sat) begin
              state_q    <= S_IDLE;
              count      <= cnt_nx;
              over_limit <= cnt_nx > limit;
              done       <= 1'b1;
            end else begin
              pre_q <= tick ? '0 : pre_q + 1'b1;
              cnt_q <= cnt_nx;
            end
          end
          S_MEAS: begin
            if (rise || sat) begin
              state_q    <= S_IDLE;
              count      <= cnt_nx;
              over_limit <= cnt_nx > limit;
              done       <= 1'b1;
            end else begin
              pre_q <= tick ? '0 : pre_q + 1'b1;
              cnt_q <= cnt_nx;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_filter_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(&hist_q || ~|hist_q));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(count));

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(over_limit));

  a_r7_start_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  a_r3_idle_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state_q == S_IDLE);
endmodule

// File: tb/tb_fan_tach_counter.sv
module tb_fan_tach_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tach_in = 1'b0;
  logic [1:0] div_sel = '0;
  logic       start = 1'b0;
  logic [7:0] limit = '0;
  logic [7:0] count;
  logic       done, over_limit;

  int nchk = 0, nerr = 0, hold_bad = 0;
  bit ended = 0;
  int    exp_q[$];
  string tag_q[$];

  fan_tach_counter dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .div_sel(div_sel),
    .start(start), .limit(limit), .count(count), .done(done),
    .over_limit(over_limit)
  );

  always #2.5 clk = ~clk;

  task automatic check(bit ok, string r, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(int c, bit o, string r);
    exp_q.push_back(c * 2 + int'(o));
    tag_q.push_back(r);
  endtask

  task automatic pulse_start(int dsel);
    div_sel = 2'(dsel);
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  task automatic rises(int per, int n);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1;
      step(per / 2);
      tach_in = 1'b0;
      step(per - per / 2);
    end
  endtask

  task automatic drain(string r);
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      step(1);
      t++;
    end
    if (exp_q.size() != 0) begin
      check(0, {r, " result timeout"}, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic measure(int dsel, int per, int nr, int lim, int c, bit o, string r);
    tach_in = 1'b0;
    limit = 8'(lim);
    step(8);
    pulse_start(dsel);
    step(4);
    rises(per, nr);
    drain(r);
  endtask

  logic       done_prev = 1'b0;
  logic [7:0] last_cnt = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected done", int'(count), -1);
        end else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check(int'(count) == e / 2, {r, " count"}, int'(count), e / 2);
          check(over_limit == e[0], {r, " over_limit"}, int'(over_limit), e % 2);
        end
        if (done_prev) hold_bad++;
      end else if (count != last_cnt) begin
        hold_bad++;
      end
      last_cnt  = count;
      done_prev = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      check(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    check(count == 8'd0, "R1 count", int'(count), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(over_limit == 1'b0, "R1 over_limit", int'(over_limit), 0);

    expect_item(153, 1, "R2 R6 above limit");
    measure(0, 153, 3, 152, 153, 1, "R6");
    expect_item(153, 0, "R6 tie");
    measure(0, 153, 3, 153, 153, 0, "R6");
    expect_item(50, 0, "R2 div2");
    measure(1, 100, 3, 60, 50, 0, "R2");
    expect_item(50, 0, "R2 div4");
    measure(2, 200, 3, 60, 50, 0, "R2");
    expect_item(125, 1, "R2 div8");
    measure(3, 1000, 3, 100, 125, 1, "R2");
    expect_item(255, 1, "R3 saturate");
    measure(0, 300, 2, 200, 255, 1, "R3");
    expect_item(255, 0, "R4 no edge");
    measure(1, 0, 0, 255, 255, 0, "R4");

    // R5: two-cycle glitch in the low phase
    tach_in = 1'b0; limit = 8'd100; step(8);
    expect_item(40, 0, "R5 glitch");
    pulse_start(0); step(4);
    tach_in = 1'b1; step(20);
    tach_in = 1'b0; step(5);
    tach_in = 1'b1; step(2);
    tach_in = 1'b0; step(13);
    rises(40, 2);
    drain("R5");

    // R7: edge before start is ignored
    tach_in = 1'b1; limit = 8'd100; step(10);
    expect_item(60, 0, "R7 prior edge");
    pulse_start(0); step(10);
    tach_in = 1'b0; step(10);
    rises(60, 3);
    drain("R7");

    // R7: restart during a measurement
    tach_in = 1'b0; step(8);
    pulse_start(0); step(4);
    tach_in = 1'b1; step(10);
    tach_in = 1'b0; step(10);
    expect_item(80, 0, "R7 restart");
    pulse_start(0); step(4);
    rises(80, 3);
    drain("R7");
    step(20);

    check(hold_bad == 0, "R8 done pulse and hold", hold_bad, 0);
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule